// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation-cache miss without software help. When the translation cache cannot map a virtual page, it hands the page number, the address-space tag and the kind of access that missed to the walker. The walker takes the table base from a base-register input at the moment it accepts the request. From that base it forms the byte address of the matching table entry in a flat, single-level table. It then fetches that one entry over a plain read port and judges it.

An entry that is not present ends the walk with a segmentation fault. An entry that is present but does not grant the requested access ends it with a protection fault. An entry that passes both tests is written into the translation cache, tagged with the captured address-space tag, and the requester is told to replay the access. Only one walk is in flight at a time. The requester learns that the walker is free through the request handshake.

Top module: `ptw_engine`

## Requirements
- R1: After a synchronous reset, and while reset is held, the walker is idle. `miss_ready` is 1, and `mem_req_valid`, `ins_valid`, `retry`, `seg_fault`, `prot_fault` and `done` are all 0. A reset in the middle of a walk abandons that walk.
- R2: A miss is accepted only when `miss_valid` and `miss_ready` are both 1. `miss_ready` is 1 only while idle. A request raised during a walk is ignored: it does not change the walk's result, and it does not start a second read.
- R3: The read address is `pt_base + miss_vpn * PTE_BYTES`, wrapping modulo 2^PA_W. Both operands are sampled in the cycle the miss is accepted. Later changes of `pt_base` do not affect the walk.
- R4: Each accepted miss issues exactly one read. `mem_req_valid` rises in the cycle after acceptance and stays high, with `mem_req_addr` stable, until a cycle in which `mem_req_ready` is 1.
- R5: The table entry uses this layout: bit 0 is the valid flag; bits 3:1 are the permissions, with bit 1 for read, bit 2 for write and bit 3 for execute; bits PFN_W+3:4 are the frame number. The requested access `miss_acc` uses bit 0 for read, bit 1 for write and bit 2 for execute.
- R6: If the returned entry has bit 0 clear, the walk ends with a one-cycle `seg_fault` and no insertion. This holds whatever its permission bits are.
- R7: If the returned entry is valid but `miss_acc` requests any access whose permission bit is 0, the walk ends with a one-cycle `prot_fault` and no insertion.
- R8: Otherwise the walk ends with a one-cycle `ins_valid` together with `retry`. The insert port carries the captured page number and tag, plus the entry's frame number and permission bits.
- R9: `done` is high for exactly one cycle per walk, in the same cycle as the outcome. That cycle is the second cycle after the one in which `mem_rsp_valid` is seen. The walker is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | PA_W | Byte base address of the linear page table |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss will be taken |
| miss_vpn | input | VPN_W | Missing virtual page number |
| miss_asid | input | ASID_W | Address-space tag of the missing access |
| miss_acc | input | 3 | Requested access: read, write, execute |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Returned entry present |
| mem_rsp_data | input | PTE_W | Returned table entry |
| ins_valid | output | 1 | Write the translation into the cache |
| ins_vpn | output | VPN_W | Page number to insert |
| ins_pfn | output | PFN_W | Frame number to insert |
| ins_prot | output | 3 | Permission bits to insert |
| ins_asid | output | ASID_W | Address-space tag to insert |
| retry | output | 1 | Replay the missing access |
| seg_fault | output | 1 | Entry not present |
| prot_fault | output | 1 | Access not permitted |
| done | output | 1 | Walk finished |

## Verification
The assertions assume that memory answers only after it has taken a request. They also assume at most one response per request, and that `mem_req_ready` and `mem_rsp_valid` are never both needed in the same idle cycle. The bench respects these assumptions: it raises `mem_req_ready` only while a request is shown, and it drives one response per walk, after a chosen latency. Miss requests raised during a busy walk are deliberately included, since the walker must ignore them. Read-request back-pressure and response delay are varied per vector. So is the base value, which moves after acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PROT_W   = 3;
    localparam int VALID_IX = 0;
    localparam int PROT_LSB = 1;
    localparam int PFN_LSB  = PROT_LSB + PROT_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_INSERT,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        VERD_OK,
        VERD_SEG,
        VERD_PROT
    } verdict_e;

    // every requested access bit must be granted by the entry
    function automatic logic access_granted(input logic [PROT_W-1:0] perm,
                                            input logic [PROT_W-1:0] want);
        return (want & ~perm) == '0;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VPN_W     = 20,
    parameter int PA_W      = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    localparam logic [PA_W-1:0] STRIDE = PA_W'(PTE_BYTES);

    logic [PA_W-1:0] offset;

    generate
        if (VPN_W >= PA_W) begin : g_trunc
            assign offset = vpn[PA_W-1:0] * STRIDE;
        end else begin : g_ext
            assign offset = {{(PA_W-VPN_W){1'b0}}, vpn} * STRIDE;
        end
    endgenerate

    assign addr = base + offset;
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PFN_W = 20
) (
    input  logic [PTE_W-1:0]  pte,
    input  logic [PROT_W-1:0] want,
    output verdict_e          verdict,
    output logic [PFN_W-1:0]  pfn,
    output logic [PROT_W-1:0] perm
);
    localparam int PFN_MSB = PFN_LSB + PFN_W - 1;

    logic present;

    assign present = pte[VALID_IX];
    assign perm    = pte[PFN_LSB-1:PROT_LSB];
    assign pfn     = pte[PFN_MSB:PFN_LSB];

    always_comb begin
        if (!present)
            verdict = VERD_SEG;
        else if (!access_granted(perm, want))
            verdict = VERD_PROT;
        else
            verdict = VERD_OK;
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PA_W   = 32,
    parameter int PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic [PROT_W-1:0] miss_acc,
    input  logic [PA_W-1:0]   addr_calc,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    input  verdict_e          verdict,
    output logic              idle,
    output logic              issuing,
    output logic [PA_W-1:0]   addr_q,
    output logic [VPN_W-1:0]  vpn_q,
    output logic [ASID_W-1:0] asid_q,
    output logic [PROT_W-1:0] acc_q,
    output logic [PTE_W-1:0]  pte_q,
    output logic              insert,
    output logic              seg,
    output logic              prot,
    output logic              finish
);
    walk_state_e state;
    verdict_e    verd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            verd_q <= VERD_OK;
            addr_q <= '0;
            vpn_q  <= '0;
            asid_q <= '0;
            acc_q  <= '0;
            pte_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (miss_valid) begin
                    vpn_q  <= miss_vpn;
                    asid_q <= miss_asid;
                    acc_q  <= miss_acc;
                    addr_q <= addr_calc;
                    state  <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    pte_q <= mem_rsp_data;
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    verd_q <= verdict;
                    state  <= (verdict == VERD_OK) ? ST_INSERT : ST_FAULT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (state == ST_IDLE);
    assign issuing = (state == ST_ISSUE);
    assign insert  = (state == ST_INSERT);
    assign seg     = (state == ST_FAULT) && (verd_q == VERD_SEG);
    assign prot    = (state == ST_FAULT) && (verd_q == VERD_PROT);
    assign finish  = (state == ST_INSERT) || (state == ST_FAULT);
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int ASID_W    = 8,
    parameter int PA_W      = 32,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PA_W-1:0]   pt_base,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic [2:0]        miss_acc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              ins_valid,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [PFN_W-1:0]  ins_pfn,
    output logic [2:0]        ins_prot,
    output logic [ASID_W-1:0] ins_asid,
    output logic              retry,
    output logic              seg_fault,
    output logic              prot_fault,
    output logic              done
);
    logic [PA_W-1:0]   addr_calc;
    logic [PTE_W-1:0]  pte_q;
    logic [PROT_W-1:0] acc_q;
    verdict_e          verdict;
    logic              insert;

    ptw_addr_gen #(
        .VPN_W(VPN_W), .PA_W(PA_W), .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .base(pt_base), .vpn(miss_vpn), .addr(addr_calc)
    );

    ptw_pte_eval #(
        .PTE_W(PTE_W), .PFN_W(PFN_W)
    ) u_eval (
        .pte(pte_q), .want(acc_q), .verdict(verdict),
        .pfn(ins_pfn), .perm(ins_prot)
    );

    ptw_fsm #(
        .VPN_W(VPN_W), .ASID_W(ASID_W), .PA_W(PA_W), .PTE_W(PTE_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .miss_asid(miss_asid), .miss_acc(miss_acc),
        .addr_calc(addr_calc),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .verdict(verdict),
        .idle(miss_ready), .issuing(mem_req_valid), .addr_q(mem_req_addr),
        .vpn_q(ins_vpn), .asid_q(ins_asid), .acc_q(acc_q), .pte_q(pte_q),
        .insert(insert), .seg(seg_fault), .prot(prot_fault), .finish(done)
    );

    assign ins_valid = insert;
    assign retry     = insert;
endmodule

// File: rtl/ptw_engine_chk.sv
module ptw_engine_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            ins_valid,
    input logic            retry,
    input logic            seg_fault,
    input logic            prot_fault,
    input logic            done
);
    logic [1:0] reads;

    always_ff @(posedge clk) begin
        if (rst || (miss_valid && miss_ready))
            reads <= '0;
        else if (mem_req_valid && mem_req_ready && reads != 2'd3)
            reads <= reads + 2'd1;
    end

    a_r1_idle_in_reset: assert property (@(posedge clk)
        rst |=> miss_ready && !mem_req_valid && !done);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || done) |-> !miss_ready);

    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    a_r4_one_read: assert property (@(posedge clk) disable iff (rst)
        done |-> reads == 2'd1);

    a_r6_seg_no_insert: assert property (@(posedge clk) disable iff (rst)
        seg_fault |-> !ins_valid && !prot_fault && !retry);

    a_r7_prot_no_insert: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> !ins_valid && !retry);

    a_r8_insert_retry: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> retry && done);

    a_r9_outcome_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({ins_valid, seg_fault, prot_fault}));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && miss_ready);
endmodule

bind ptw_engine ptw_engine_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .ins_valid(ins_valid), .retry(retry),
    .seg_fault(seg_fault), .prot_fault(prot_fault), .done(done)
);

// File: tb/sim_ptw_engine.sv
`timescale 1ns/1ps
module sim_ptw_engine;
    localparam int VPN_W = 20, PFN_W = 20, ASID_W = 8, PA_W = 32, PTE_W = 32;
    localparam int NV = 8;

    localparam logic [VPN_W-1:0]  T_VPN  [NV] = '{20'h00001, 20'h00010, 20'hFFFFF, 20'h00ABC,
                                                  20'h00005, 20'h00777, 20'h01234, 20'h00042};
    localparam logic [ASID_W-1:0] T_ASID [NV] = '{8'h01, 8'h02, 8'hFF, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
    localparam logic [2:0]        T_ACC  [NV] = '{3'b001, 3'b010, 3'b001, 3'b100, 3'b011, 3'b100, 3'b101, 3'b101};
    localparam logic [PFN_W-1:0]  T_PFN  [NV] = '{20'h12345, 20'hABCDE, 20'h55555, 20'h00001,
                                                  20'hFFFFF, 20'h0F0F0, 20'h2468A, 20'h13579};
    localparam logic [2:0]        T_PERM [NV] = '{3'b111, 3'b001, 3'b111, 3'b100, 3'b011, 3'b000, 3'b101, 3'b001};
    localparam logic              T_V    [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [PA_W-1:0]   T_BASE [NV] = '{32'h1000_0000, 32'h2000_0100, 32'h0000_0000, 32'h8000_0000,
                                                  32'hFFFF_FFF0, 32'h0040_0000, 32'h1234_5670, 32'h0000_1000};
    localparam int                T_RDLY [NV] = '{0, 1, 0, 2, 0, 3, 0, 1};
    localparam int                T_LAT  [NV] = '{0, 0, 2, 3, 1, 0, 2, 1};
    localparam logic              T_POKE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 0, rst = 1;
    logic [PA_W-1:0] pt_base = '0;
    logic miss_valid = 0, miss_ready;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic [ASID_W-1:0] miss_asid = '0;
    logic [2:0] miss_acc = '0;
    logic mem_req_valid, mem_req_ready = 0;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 0;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic ins_valid, retry, seg_fault, prot_fault, done;
    logic [VPN_W-1:0] ins_vpn;
    logic [PFN_W-1:0] ins_pfn;
    logic [2:0] ins_prot;
    logic [ASID_W-1:0] ins_asid;

    int checks = 0, fails = 0, nreads = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptw_engine u0 (
        .clk(clk), .rst(rst), .pt_base(pt_base),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .miss_asid(miss_asid), .miss_acc(miss_acc),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn),
        .ins_prot(ins_prot), .ins_asid(ins_asid),
        .retry(retry), .seg_fault(seg_fault), .prot_fault(prot_fault), .done(done)
    );

    always @(posedge clk) if (mem_req_valid && mem_req_ready) nreads <= nreads + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        chk(miss_ready === 1'b1, req, 64'(miss_ready), 64'd1);
        chk({mem_req_valid, ins_valid, retry, seg_fault, prot_fault, done} === 6'b0,
            req, 64'({mem_req_valid, ins_valid, retry, seg_fault, prot_fault, done}), 64'd0);
    endtask

    task automatic walk(input int i);
        logic [PA_W-1:0] exp_addr;
        logic [PTE_W-1:0] pte;
        int verd, r0;
        exp_addr = T_BASE[i] + (PA_W'(T_VPN[i]) * 32'd4);
        pte = '0;
        pte[0] = T_V[i];
        pte[3:1] = T_PERM[i];
        pte[PFN_W+3:4] = T_PFN[i];
        pte[PTE_W-1] = 1'b1;
        if (!T_V[i]) verd = 1;
        else if ((T_ACC[i] & ~T_PERM[i]) != 3'b0) verd = 2;
        else verd = 0;

        @(negedge clk);
        chk(miss_ready === 1'b1, "R2 ready in idle", 64'(miss_ready), 64'd1);
        pt_base = T_BASE[i]; miss_vpn = T_VPN[i]; miss_asid = T_ASID[i]; miss_acc = T_ACC[i];
        miss_valid = 1;
        r0 = nreads;
        @(negedge clk);
        miss_valid = 0; pt_base = ~T_BASE[i]; miss_vpn = ~T_VPN[i];
        for (int k = 0; k < T_RDLY[i]; k++) begin
            chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R4 request held",
                64'(mem_req_addr), 64'(exp_addr));
            @(negedge clk);
        end
        chk(mem_req_valid === 1'b1, "R4 request valid", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr === exp_addr, "R3 entry address", 64'(mem_req_addr), 64'(exp_addr));
        chk(miss_ready === 1'b0, "R2 busy", 64'(miss_ready), 64'd0);
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        if (T_POKE[i]) begin
            miss_valid = 1; miss_asid = ~T_ASID[i];
            @(negedge clk);
            miss_valid = 0;
        end
        for (int k = 0; k < T_LAT[i]; k++) @(negedge clk);
        chk(done === 1'b0 && mem_req_valid === 1'b0, "R9 no early done", 64'(done), 64'd0);
        mem_rsp_valid = 1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 0; mem_rsp_data = '1;
        chk(done === 1'b0, "R9 done timing", 64'(done), 64'd0);
        @(negedge clk);
        chk(done === 1'b1, "R9 done pulse", 64'(done), 64'd1);
        if (verd == 0) begin
            chk(ins_valid === 1'b1 && retry === 1'b1, "R8 insert and retry",
                64'({ins_valid, retry}), 64'd3);
            chk(ins_vpn === T_VPN[i], "R8 insert vpn", 64'(ins_vpn), 64'(T_VPN[i]));
            chk(ins_pfn === T_PFN[i], "R5 R8 insert pfn", 64'(ins_pfn), 64'(T_PFN[i]));
            chk(ins_prot === T_PERM[i], "R5 R8 insert perm", 64'(ins_prot), 64'(T_PERM[i]));
            chk(ins_asid === T_ASID[i], "R8 insert tag", 64'(ins_asid), 64'(T_ASID[i]));
            chk({seg_fault, prot_fault} === 2'b0, "R8 no fault", 64'({seg_fault, prot_fault}), 64'd0);
        end else if (verd == 1) begin
            chk({seg_fault, prot_fault, ins_valid, retry} === 4'b1000, "R6 segmentation fault",
                64'({seg_fault, prot_fault, ins_valid, retry}), 64'h8);
        end else begin
            chk({seg_fault, prot_fault, ins_valid, retry} === 4'b0100, "R7 protection fault",
                64'({seg_fault, prot_fault, ins_valid, retry}), 64'h4);
        end
        @(negedge clk);
        idle_outputs("R9 back to idle");
        chk(nreads - r0 == 1, "R4 one read per miss", 64'(nreads - r0), 64'd1);
        if (T_POKE[i]) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b0, "R2 busy request ignored", 64'(mem_req_valid), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_outputs("R1 reset state");
        rst = 0;
        for (int i = 0; i < NV; i++) walk(i);

        // R1: reset in the middle of a walk
        @(negedge clk);
        pt_base = 32'h3000_0000; miss_vpn = 20'h00009; miss_valid = 1;
        @(negedge clk);
        miss_valid = 0;
        chk(mem_req_valid === 1'b1, "R1 walk started", 64'(mem_req_valid), 64'd1);
        rst = 1;
        @(negedge clk);
        idle_outputs("R1 reset abandons walk");
        rst = 0;
        @(negedge clk);
        idle_outputs("R1 stays idle after reset");
        walk(0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule